// File: doc/BRIEF.md
# Configuration Readback Engine with State Capture

This block reads the stored configuration of a device back out as a serial bit stream. When a readback request arrives after the device has been flagged as configured, the engine walks a frame memory from a programmable first frame through successive frames. It emits every bit of a frame most significant bit first, one bit per clock, with a valid flag, and raises a pulse on the last bit of each frame. The header and length field of the configuration stream are never emitted. A frame sent back therefore has the same bit layout as the frame that was loaded.

The frame memory sits outside the block and is a plain synchronous RAM. The engine drives a read enable and a frame and bit address, and the addressed bit returns one clock later. The engine also drives the write strobe of the capture storage, which snapshots internal register state. Four capture policies are selected by a 2-bit mode: never, once as readback is accepted, every cycle while an active-low trigger is held low, or on either of those two events. Software sets the first frame, the final frame and the capture mode through a small register write port.

Top module: `cfg_readback`

## Requirements
- R1: After reset, `mem_rd`, `rd_valid`, `frame_done` and `cap_we` are low. The first-frame register is 0, the final-frame register is NUM_FRAMES-1 and the capture mode is 0.
- R2: A write with `reg_we` high stores the low bits of `reg_wdata`. Address 0 sets the first frame of a readback, address 1 sets the final frame, and address 2 sets the capture mode from bits 1:0.
- R3: An accepted request starts reading at the first-frame register value in the next cycle. Frames follow in increasing order. Within each frame the bit address counts from FRAME_BITS-1 down to 0, one per clock. `rd_valid` and `rd_data` present each bit one cycle after its address, which is the RAM latency.
- R4: `frame_done` is high together with `rd_valid` exactly when the bit shown is bit 0 of a frame.
- R5: Readback returns to idle after bit 0 of the final-frame register's frame, or after bit 0 of frame NUM_FRAMES-1, whichever is reached first. No further reads are issued after that.
- R6: `rb_stop` high while reading suppresses the read in that cycle and returns the engine to idle. `rd_valid` is low from the following cycle on.
- R7: While `cfg_done` is low, requests are not accepted, any readback in progress ends at once, and `cap_we` stays low.
- R8: Capture mode 0 never raises `cap_we`.
- R9: Capture mode 1 raises `cap_we` for the single cycle in which an idle engine accepts a request. That cycle comes before the first `mem_rd`.
- R10: Capture mode 2 raises `cap_we` on every cycle in which `cap_trig_n` is low and the device is configured, whether or not a readback is running.
- R11: Capture mode 3 raises `cap_we` on either a mode-1 event or a mode-2 event.
- R12: A request made while a readback is running neither restarts it nor alters its output, and it raises no entry capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 first frame, 1 final frame, 2 capture mode) |
| reg_wdata | input | REG_DW | Register write data |
| rb_req | input | 1 | Readback request |
| rb_stop | input | 1 | Abort the running readback |
| cfg_done | input | 1 | Device is configured |
| cap_trig_n | input | 1 | Internal capture trigger, active low |
| mem_rd | output | 1 | Frame memory read enable |
| mem_frame | output | FAW | Frame memory frame address |
| mem_bit | output | BAW | Frame memory bit address |
| mem_rdata | input | 1 | Frame memory read data, one cycle after the address |
| rd_data | output | 1 | Serial readback data |
| rd_valid | output | 1 | `rd_data` holds a readback bit |
| frame_done | output | 1 | Last bit of a frame is on `rd_data` |
| cap_we | output | 1 | Capture storage write strobe |

## Verification
The assertions take the capture trigger, the request and the stop input as already synchronous to `clk`. They also take the final-frame register as unchanged while a readback runs, because the end-of-readback check compares against its live value. The stimulus changes every input on the falling edge. It writes the control registers only while the engine is idle. It models the frame memory as a one-cycle synchronous RAM whose contents follow a fixed function of frame and bit address.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

    typedef enum logic [1:0] {
        CAP_NONE  = 2'd0,
        CAP_ENTRY = 2'd1,
        CAP_TRIG  = 2'd2,
        CAP_BOTH  = 2'd3
    } cap_mode_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    localparam logic [1:0] REG_FIRST = 2'd0;
    localparam logic [1:0] REG_FINAL = 2'd1;
    localparam logic [1:0] REG_MODE  = 2'd2;

    function automatic logic entry_capture(cap_mode_e m);
        return m[0];
    endfunction

    function automatic logic trig_capture(cap_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/rbk_regs.sv
module rbk_regs
    import rbk_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int REG_DW     = 8,
    localparam int FAW       = $clog2(NUM_FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [FAW-1:0]    first_frame,
    output logic [FAW-1:0]    final_frame,
    output cap_mode_e         mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            first_frame <= '0;
            final_frame <= FAW'(NUM_FRAMES - 1);
            mode        <= CAP_NONE;
        end else if (we) begin
            case (addr)
                REG_FIRST: first_frame <= wdata[FAW-1:0];
                REG_FINAL: final_frame <= wdata[FAW-1:0];
                REG_MODE:  mode        <= cap_mode_e'(wdata[1:0]);
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/rbk_seq.sv
module rbk_seq
    import rbk_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int FRAME_BITS = 16,
    localparam int FAW       = $clog2(NUM_FRAMES),
    localparam int BAW       = $clog2(FRAME_BITS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req,
    input  logic           stop,
    input  logic           cfg_done,
    input  logic [FAW-1:0] first_frame,
    input  logic [FAW-1:0] final_frame,
    output logic           accept,
    output logic           rd_en,
    output logic [FAW-1:0] frame_q,
    output logic [BAW-1:0] bit_q
);

    localparam logic [FAW-1:0] FRAME_TOP = FAW'(NUM_FRAMES - 1);
    localparam logic [BAW-1:0] BIT_TOP   = BAW'(FRAME_BITS - 1);

    seq_state_e st_q;
    logic       at_frame_end;
    logic       at_run_end;

    always_comb begin
        accept       = (st_q == SEQ_IDLE) && req && cfg_done;
        rd_en        = (st_q == SEQ_RUN) && !stop && cfg_done;
        at_frame_end = (bit_q == '0);
        at_run_end   = (frame_q == final_frame) || (frame_q == FRAME_TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SEQ_IDLE;
            frame_q <= '0;
            bit_q   <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        st_q    <= SEQ_RUN;
                        frame_q <= first_frame;
                        bit_q   <= BIT_TOP;
                    end
                end
                SEQ_RUN: begin
                    if (!rd_en) begin
                        st_q <= SEQ_IDLE;
                    end else if (at_frame_end) begin
                        if (at_run_end) begin
                            st_q <= SEQ_IDLE;
                        end else begin
                            frame_q <= frame_q + FAW'(1);
                            bit_q   <= BIT_TOP;
                        end
                    end else begin
                        bit_q <= bit_q - BAW'(1);
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    // R3
    seq_bit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bit_q != '0) |=> (!rd_en || bit_q == $past(bit_q) - BAW'(1)));

    // R3
    seq_frame_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bit_q == '0) |=>
            (!rd_en || (frame_q == $past(frame_q) + FAW'(1) && bit_q == BIT_TOP)));

    // R5
    seq_final_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bit_q == '0 && frame_q == final_frame) |=> !rd_en);

endmodule

// File: rtl/rbk_cap.sv
module rbk_cap
    import rbk_pkg::*;
(
    input  logic      cfg_done,
    input  logic      accept,
    input  logic      trig_n,
    input  cap_mode_e mode,
    output logic      cap_we
);

    always_comb begin
        cap_we = cfg_done &&
                 ((entry_capture(mode) && accept) ||
                  (trig_capture(mode) && !trig_n));
    end

endmodule

// File: rtl/rbk_out.sv
module rbk_out #(
    parameter int BAW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_en,
    input  logic [BAW-1:0] bit_addr,
    input  logic           mem_rdata,
    output logic           rd_data,
    output logic           rd_valid,
    output logic           frame_done
);

    logic valid_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            valid_q <= rd_en;
            last_q  <= rd_en && (bit_addr == '0);
        end
    end

    always_comb begin
        rd_valid   = valid_q;
        frame_done = last_q;
        rd_data    = valid_q & mem_rdata;
    end

endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
    import rbk_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int FRAME_BITS = 16,
    parameter int REG_DW     = 8,
    localparam int FAW       = $clog2(NUM_FRAMES),
    localparam int BAW       = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              rb_req,
    input  logic              rb_stop,
    input  logic              cfg_done,
    input  logic              cap_trig_n,
    output logic              mem_rd,
    output logic [FAW-1:0]    mem_frame,
    output logic [BAW-1:0]    mem_bit,
    input  logic              mem_rdata,
    output logic              rd_data,
    output logic              rd_valid,
    output logic              frame_done,
    output logic              cap_we
);

    logic [FAW-1:0] first_frame;
    logic [FAW-1:0] final_frame;
    cap_mode_e      mode;
    logic           accept;

    rbk_regs #(.NUM_FRAMES(NUM_FRAMES), .REG_DW(REG_DW)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .first_frame(first_frame), .final_frame(final_frame), .mode(mode)
    );

    rbk_seq #(.NUM_FRAMES(NUM_FRAMES), .FRAME_BITS(FRAME_BITS)) u_seq (
        .clk(clk), .rst(rst), .req(rb_req), .stop(rb_stop), .cfg_done(cfg_done),
        .first_frame(first_frame), .final_frame(final_frame),
        .accept(accept), .rd_en(mem_rd), .frame_q(mem_frame), .bit_q(mem_bit)
    );

    rbk_cap u_cap (
        .cfg_done(cfg_done), .accept(accept), .trig_n(cap_trig_n),
        .mode(mode), .cap_we(cap_we)
    );

    rbk_out #(.BAW(BAW)) u_out (
        .clk(clk), .rst(rst), .rd_en(mem_rd), .bit_addr(mem_bit),
        .mem_rdata(mem_rdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .frame_done(frame_done)
    );

    // R6
    stop_halts_reads_chk: assert property (@(posedge clk) disable iff (rst)
        rb_stop |=> !mem_rd);

    // R7
    unconfigured_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |-> (!mem_rd && !cap_we));

    // R9
    entry_capture_first_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == CAP_ENTRY && cap_we) |-> !mem_rd);

    // R4
    done_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> rd_valid);

    // R3
    valid_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(mem_rd));

endmodule

// File: tb/tb_cfg_readback.sv
`timescale 1ns/1ps
module tb_cfg_readback;

    localparam int NF  = 8;
    localparam int FB  = 16;
    localparam int FAW = $clog2(NF);
    localparam int BAW = $clog2(FB);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           reg_we = 1'b0;
    logic [1:0]     reg_addr = '0;
    logic [7:0]     reg_wdata = '0;
    logic           rb_req = 1'b0;
    logic           rb_stop = 1'b0;
    logic           cfg_done = 1'b0;
    logic           cap_trig_n = 1'b1;
    logic           mem_rd;
    logic [FAW-1:0] mem_frame;
    logic [BAW-1:0] mem_bit;
    logic           mem_rdata = 1'b0;
    logic           rd_data, rd_valid, frame_done, cap_we;

    int checks = 0;
    int fails  = 0;
    logic sb_on = 1'b0;
    logic [1:0] exp_q[$];

    always #4 clk = ~clk;

    cfg_readback #(.NUM_FRAMES(NF), .FRAME_BITS(FB), .REG_DW(8)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rb_req(rb_req), .rb_stop(rb_stop),
        .cfg_done(cfg_done), .cap_trig_n(cap_trig_n), .mem_rd(mem_rd),
        .mem_frame(mem_frame), .mem_bit(mem_bit), .mem_rdata(mem_rdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .frame_done(frame_done),
        .cap_we(cap_we)
    );

    function automatic logic pat(int f, int b);
        logic [31:0] x;
        x = f * 37 + b * 11 + (f ^ b);
        return ^x[5:0];
    endfunction

    // frame memory: synchronous read, one cycle latency
    always @(posedge clk) if (mem_rd) mem_rdata <= pat(int'(mem_frame), int'(mem_bit));

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        #2;
        if (sb_on) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5", "unexpected rd_valid", 1, 0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e[1], "R3", "rd_data", rd_data, e[1]);
                    check(frame_done == e[0], "R4", "frame_done", frame_done, e[0]);
                end
            end else begin
                if (frame_done) check(0, "R4", "frame_done without valid", 1, 0);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic expect_run(int first, int last);
        int f = first;
        forever begin
            for (int b = FB - 1; b >= 0; b--) exp_q.push_back({pat(f, b), (b == 0) ? 1'b1 : 1'b0});
            if (f == last || f == NF - 1) break;
            f++;
        end
    endtask

    // pulse a request; return cap_we / mem_rd seen in the accept cycle
    task automatic pulse_req(output logic cw, output logic rd);
        @(negedge clk);
        rb_req = 1'b1;
        #1;
        cw = cap_we; rd = mem_rd;
        @(negedge clk);
        rb_req = 1'b0;
    endtask

    task automatic drain(string req);
        int n = 0;
        while (exp_q.size() != 0 && n < 1000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        #3;
        check(exp_q.size() == 0, req, "items left in scoreboard", exp_q.size(), 0);
        check(mem_rd == 1'b0, "R5", "mem_rd after end", mem_rd, 0);
    endtask

    initial begin : stim
        logic cw, rd;
        int cnt;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(!mem_rd && !rd_valid && !frame_done && !cap_we, "R1", "outputs in reset",
              {mem_rd, rd_valid, frame_done, cap_we}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R7: not configured, request and trigger ignored
        wr(2'd2, 8'd3);
        cap_trig_n = 1'b0;
        pulse_req(cw, rd);
        check(cw == 1'b0, "R7", "cap_we while unconfigured", cw, 0);
        cnt = 0;
        repeat (20) begin @(negedge clk); #1; cnt += int'(mem_rd) + int'(rd_valid) + int'(cap_we); end
        check(cnt == 0, "R7", "activity while unconfigured", cnt, 0);
        cap_trig_n = 1'b1;

        // R1 defaults: reset again, full readback from frame 0 to NF-1, mode 0
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        cfg_done = 1'b1;
        cap_trig_n = 1'b0;
        sb_on = 1'b1;
        expect_run(0, NF - 1);
        pulse_req(cw, rd);
        check(cw == 1'b0, "R1", "default mode capture", cw, 0);
        check(rd == 1'b0, "R3", "no read in accept cycle", rd, 0);
        #1;
        check(mem_rd == 1'b1 && mem_frame == 0 && mem_bit == BAW'(FB - 1), "R1",
              "first address from default registers", int'(mem_frame), 0);
        drain("R1");
        cap_trig_n = 1'b1;

        // R2, R5, R9, R12: start at 3, end at 5, entry capture
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd5);
        wr(2'd2, 8'd1);
        expect_run(3, 5);
        pulse_req(cw, rd);
        check(cw == 1'b1, "R9", "entry capture on accept", cw, 1);
        check(rd == 1'b0, "R9", "capture before first read", rd, 0);
        #1;
        check(mem_frame == FAW'(3), "R2", "first frame register used", int'(mem_frame), 3);
        check(cap_we == 1'b0, "R9", "entry capture single cycle", cap_we, 0);
        repeat (5) @(negedge clk);
        rb_req = 1'b1;
        #1;
        check(cap_we == 1'b0, "R12", "no capture on request while running", cap_we, 0);
        @(negedge clk);
        rb_req = 1'b0;
        drain("R12");

        // R5: final frame below first frame, ends at NF-1
        wr(2'd0, 8'd6);
        wr(2'd1, 8'd2);
        wr(2'd2, 8'd0);
        expect_run(6, 2);
        pulse_req(cw, rd);
        drain("R5");

        // R8: mode 0 with trigger low during a readback
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd0);
        expect_run(0, 0);
        cap_trig_n = 1'b0;
        pulse_req(cw, rd);
        cnt = int'(cw);
        repeat (FB + 4) begin @(negedge clk); #1; cnt += int'(cap_we); end
        check(cnt == 0, "R8", "cap_we count in mode 0", cnt, 0);
        cap_trig_n = 1'b1;
        drain("R8");
        sb_on = 1'b0;

        // R6: stop mid-frame
        wr(2'd1, 8'd7);
        pulse_req(cw, rd);
        repeat (5) @(negedge clk);
        rb_stop = 1'b1;
        @(negedge clk);
        rb_stop = 1'b0;
        cnt = 0;
        #1;
        repeat (10) begin cnt += int'(mem_rd) + int'(rd_valid); @(negedge clk); #1; end
        check(cnt == 0, "R6", "activity after stop", cnt, 0);

        // R7: configuration lost during readback
        pulse_req(cw, rd);
        repeat (4) @(negedge clk);
        cfg_done = 1'b0;
        @(negedge clk);
        cfg_done = 1'b1;
        cnt = 0;
        #1;
        repeat (10) begin cnt += int'(mem_rd) + int'(rd_valid); @(negedge clk); #1; end
        check(cnt == 0, "R7", "activity after configured dropped", cnt, 0);

        // R10: trigger mode while idle
        wr(2'd2, 8'd2);
        @(negedge clk);
        cap_trig_n = 1'b0;
        cnt = 0;
        repeat (3) begin #1; cnt += int'(cap_we); @(negedge clk); end
        cap_trig_n = 1'b1;
        repeat (3) begin #1; cnt += int'(cap_we); @(negedge clk); end
        check(cnt == 3, "R10", "cap_we cycles with trigger low", cnt, 3);
        pulse_req(cw, rd);
        check(cw == 1'b0, "R10", "no entry capture in trigger mode", cw, 0);
        rb_stop = 1'b1; @(negedge clk); rb_stop = 1'b0;

        // R11: both events
        wr(2'd2, 8'd3);
        pulse_req(cw, rd);
        check(cw == 1'b1, "R11", "entry event in mode 3", cw, 1);
        cap_trig_n = 1'b0;
        cnt = 0;
        repeat (4) begin #1; cnt += int'(cap_we); @(negedge clk); end
        cap_trig_n = 1'b1;
        #1;
        cnt += int'(cap_we);
        check(cnt == 4, "R11", "trigger event in mode 3", cnt, 4);
        rb_stop = 1'b1; @(negedge clk); rb_stop = 1'b0;
        repeat (3) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule